// File: doc/BRIEF.md
# Halted-Hart Handshake Region

This block is a small memory-mapped slave inside a debug unit. It is the meeting point between harts parked in debug mode and the debugger. A parked hart runs a polling loop from a fixed ROM. In that loop it announces that it is halted, reads its own flag byte, and jumps on when the debugger has asked it to do so. The hart side is a plain word bus: address, write data, byte strobes, and combinational read data.

On the debugger side there is a selection index plus two request pulses. One request asks the selected hart to run a command, and it carries a kind: abstract area, program buffer or resume entry. The other asks the hart to leave debug mode. A set of status outputs reports on the selected hart: halted, command pending, resume pending and resume acknowledged. A sticky exception bit and a combinational busy indication are also reported.

A hart learns where to go next by fetching one instruction word that the block builds. That word is an unconditional PC-relative jump with no link register. It is computed from the latched command kind and the configured target addresses.

Top module: `dm_hart_handshake`

## Requirements
- R1: After reset, every halted, command, resume and acknowledge bit is zero, the exception bit is zero, and the jump word selects the abstract area.
- R2: A hart write to offset 0x100 with at least one strobe set, whose data is a hart index below NUM_HARTS, marks that hart halted.
- R3: An accepted command request for a halted hart sets bit 0 of that hart's flag byte. Flag byte h sits at byte address 0x400+h, and a word read returns byte h in lane h mod 4.
- R4: A command request made while any command bit is set or being set raises busy in the same cycle, and it leaves all flags unchanged. At most one command bit is ever set.
- R5: A command request for a hart that is not halted is ignored and does not raise busy.
- R6: Any hart write to offset 0x104 clears the command bit.
- R7: A resume request for a halted hart sets bit 1 of its flag byte and clears its acknowledge bit. Several harts may hold resume bits at once. A request for a hart that is not halted is ignored.
- R8: A hart write to offset 0x108 carrying hart index h clears h's resume bit, sets h's acknowledge bit, and clears h's halted bit.
- R9: A write to offset 0x10C sets a sticky exception bit. Only the next accepted command request clears it.
- R10: Reads of unmapped offsets return zero. Writes to unmapped offsets, and writes with all strobes low, change nothing.
- R11: A read of offset 0x300 returns a jump word with opcode 0x6F and rd = 0. Its immediate is the target minus 0x300, encoded as imm[20], imm[10:1], imm[11], imm[19:12] from bit 31 downward. Kind 0 selects the abstract area, kind 1 the program buffer and kind 2 the resume entry. The word is latched one cycle before the command bit becomes visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hartValid | input | 1 | Hart bus access valid |
| hartWrite | input | 1 | 1 = write, 0 = read |
| hartAddr | input | ADDR_W | Byte offset of the access |
| hartWdata | input | 32 | Write data (hart index for status writes) |
| hartStrb | input | 4 | Byte strobes |
| hartRdata | output | 32 | Read data, combinational |
| dbgSel | input | ID_W | Hart selected by the debugger |
| dbgGoReq | input | 1 | Command request pulse |
| dbgGoKind | input | 2 | Command kind: 0 abstract, 1 program buffer, 2 resume entry |
| dbgResumeReq | input | 1 | Resume request pulse |
| dbgBusy | output | 1 | Command request refused because a command is outstanding |
| statHalted | output | 1 | Selected hart is halted |
| statGoPending | output | 1 | Selected hart has its command bit set |
| statResumePending | output | 1 | Selected hart has its resume bit set |
| statResumeAck | output | 1 | Selected hart acknowledged its resume |
| dbgException | output | 1 | Sticky exception status |

## Verification
The bench checks the packed flag word with two harts holding resume bits at once. A design that mis-lanes the bytes would show the bits in the wrong byte. It also sends a second command while one is outstanding. A design without the busy check would set two command bits, and the hart would run the wrong program. It tries requests to harts that are not halted, and writes with all strobes low, which a careless design would act on. Finally it reads the jump word for all three kinds, which catches a wrong immediate bit layout or a wrong target.

// File: rtl/dmhs_pkg.sv
package dmhs_pkg;
  localparam int ADDR_W_DEF = 12;
  localparam logic [11:0] OFF_HALT = 12'h100;
  localparam logic [11:0] OFF_GOACK = 12'h104;
  localparam logic [11:0] OFF_RESACK = 12'h108;
  localparam logic [11:0] OFF_EXC = 12'h10C;
  localparam logic [11:0] OFF_JUMP = 12'h300;
  localparam logic [11:0] OFF_FLAGS = 12'h400;

  typedef enum logic [1:0] {
    JMP_ABSTRACT = 2'd0,
    JMP_PROGBUF  = 2'd1,
    JMP_RESUME   = 2'd2
  } jumpKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      haltSet;
    logic      goClear;
    logic      ackSet;
    logic      excSet;
    logic      excClr;
    logic      goLoad;
    logic      goSet;
    logic      resumeSet;
    logic [7:0] hartIdx;
    logic [7:0] goIdx;
    logic [7:0] resIdx;
    jumpKind_e kind;
  } hsStrobe_t;

  function automatic logic [31:0] encodeJump(input logic [31:0] off);
    return {off[20], off[10:1], off[11], off[19:12], 5'd0, 7'h6F};
  endfunction
endpackage

// File: rtl/dmhs_ctrl.sv
module dmhs_ctrl
  import dmhs_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int ID_W = 2,
  parameter int ADDR_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hartValid,
  input  logic                 hartWrite,
  input  logic [ADDR_W-1:0]    hartAddr,
  input  logic [31:0]          hartWdata,
  input  logic [3:0]           hartStrb,
  input  logic [ID_W-1:0]      dbgSel,
  input  logic                 dbgGoReq,
  input  logic [1:0]           dbgGoKind,
  input  logic                 dbgResumeReq,
  input  logic [NUM_HARTS-1:0] haltedVec,
  input  logic [NUM_HARTS-1:0] goVec,
  output hsStrobe_t            st,
  output logic                 dbgBusy
);
  logic wrOk, idOk, selHalted, goBusy, goStage;
  logic [7:0] goHartQ;

  assign wrOk = hartValid && hartWrite && (|hartStrb);
  assign idOk = hartWdata < 32'(NUM_HARTS);
  assign selHalted = haltedVec[dbgSel];
  assign goBusy = (|goVec) || goStage;
  assign dbgBusy = dbgGoReq && goBusy;

  always_comb begin
    st = '0;
    st.hartIdx = hartWdata[7:0];
    st.haltSet = wrOk && (hartAddr == ADDR_W'(OFF_HALT)) && idOk;
    st.goClear = wrOk && (hartAddr == ADDR_W'(OFF_GOACK));
    st.ackSet = wrOk && (hartAddr == ADDR_W'(OFF_RESACK)) && idOk;
    st.excSet = wrOk && (hartAddr == ADDR_W'(OFF_EXC));
    st.goLoad = dbgGoReq && selHalted && !goBusy && (dbgGoKind != 2'd3);
    st.excClr = st.goLoad;
    st.kind = jumpKind_e'(dbgGoKind);
    st.goSet = goStage;
    st.goIdx = goHartQ;
    st.resumeSet = dbgResumeReq && selHalted;
    st.resIdx = 8'(dbgSel);
  end

  // jump kind is latched first; the command bit follows one cycle later
  always_ff @(posedge clk) begin
    if (!rstN) begin
      goStage <= 1'b0;
      goHartQ <= '0;
    end else begin
      goStage <= st.goLoad;
      if (st.goLoad) goHartQ <= 8'(dbgSel);
    end
  end

  // R4
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    goBusy |-> !st.goLoad);
  // R5
  go_needs_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.goSet |-> haltedVec[goHartQ[ID_W-1:0]]);
endmodule

// File: rtl/dmhs_data.sv
module dmhs_data
  import dmhs_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int ID_W = 2,
  parameter int ADDR_W = 12,
  parameter logic [31:0] ABSTRACT_ADDR = 32'h380,
  parameter logic [31:0] PROGBUF_ADDR = 32'h360,
  parameter logic [31:0] RESUME_ADDR = 32'h804
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  hsStrobe_t            st,
  input  logic                 hartValid,
  input  logic                 hartWrite,
  input  logic [ADDR_W-1:0]    hartAddr,
  input  logic [ID_W-1:0]      dbgSel,
  output logic [31:0]          hartRdata,
  output logic [NUM_HARTS-1:0] haltedVec,
  output logic [NUM_HARTS-1:0] goVec,
  output logic                 statHalted,
  output logic                 statGoPending,
  output logic                 statResumePending,
  output logic                 statResumeAck,
  output logic                 dbgException
);
  logic [NUM_HARTS-1:0] halted, goFlag, resumeFlag, resumeAck;
  logic exc;
  jumpKind_e kindQ;
  logic [31:0] target, jumpWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halted <= '0;
      goFlag <= '0;
      resumeFlag <= '0;
      resumeAck <= '0;
      exc <= 1'b0;
      kindQ <= JMP_ABSTRACT;
    end else begin
      if (st.haltSet) halted[st.hartIdx[ID_W-1:0]] <= 1'b1;
      if (st.goLoad) kindQ <= st.kind;
      if (st.goClear) goFlag <= '0;
      if (st.goSet) goFlag[st.goIdx[ID_W-1:0]] <= 1'b1;
      if (st.resumeSet) begin
        resumeFlag[st.resIdx[ID_W-1:0]] <= 1'b1;
        resumeAck[st.resIdx[ID_W-1:0]] <= 1'b0;
      end
      if (st.ackSet) begin
        resumeFlag[st.hartIdx[ID_W-1:0]] <= 1'b0;
        resumeAck[st.hartIdx[ID_W-1:0]] <= 1'b1;
        halted[st.hartIdx[ID_W-1:0]] <= 1'b0;
      end
      if (st.excClr) exc <= 1'b0;
      if (st.excSet) exc <= 1'b1;
    end
  end

  always_comb begin
    case (kindQ)
      JMP_PROGBUF: target = PROGBUF_ADDR;
      JMP_RESUME:  target = RESUME_ADDR;
      default:     target = ABSTRACT_ADDR;
    endcase
    jumpWord = encodeJump(target - 32'(OFF_JUMP));
  end

  always_comb begin
    hartRdata = '0;
    if (hartValid && !hartWrite) begin
      if (hartAddr == ADDR_W'(OFF_JUMP)) hartRdata = jumpWord;
      for (int h = 0; h < NUM_HARTS; h++) begin
        if (hartAddr[ADDR_W-1:2] == ADDR_W'(32'(OFF_FLAGS) + h) >> 2)
          hartRdata[8*(h%4) +: 8] = {6'd0, resumeFlag[h], goFlag[h]};
      end
    end
  end

  assign haltedVec = halted;
  assign goVec = goFlag;
  assign statHalted = halted[dbgSel];
  assign statGoPending = goFlag[dbgSel];
  assign statResumePending = resumeFlag[dbgSel];
  assign statResumeAck = resumeAck[dbgSel];
  assign dbgException = exc;

  // R4
  go_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(goFlag));
  // R11
  jump_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|goFlag) |-> $stable(jumpWord));
  // R2
  halt_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.haltSet |=> ((halted & ~$past(halted)) == '0));
  // R8
  resume_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.ackSet |=> !resumeFlag[$past(st.hartIdx[ID_W-1:0])]);
  // R9
  exc_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (exc && !st.excClr) |=> exc);
endmodule

// File: rtl/dm_hart_handshake.sv
module dm_hart_handshake
  import dmhs_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int ID_W = $clog2(NUM_HARTS),
  parameter int ADDR_W = ADDR_W_DEF,
  parameter logic [31:0] ABSTRACT_ADDR = 32'h380,
  parameter logic [31:0] PROGBUF_ADDR = 32'h360,
  parameter logic [31:0] RESUME_ADDR = 32'h804
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hartValid,
  input  logic              hartWrite,
  input  logic [ADDR_W-1:0] hartAddr,
  input  logic [31:0]       hartWdata,
  input  logic [3:0]        hartStrb,
  output logic [31:0]       hartRdata,
  input  logic [ID_W-1:0]   dbgSel,
  input  logic              dbgGoReq,
  input  logic [1:0]        dbgGoKind,
  input  logic              dbgResumeReq,
  output logic              dbgBusy,
  output logic              statHalted,
  output logic              statGoPending,
  output logic              statResumePending,
  output logic              statResumeAck,
  output logic              dbgException
);
  hsStrobe_t st;
  logic [NUM_HARTS-1:0] haltedVec, goVec;

  dmhs_ctrl #(.NUM_HARTS(NUM_HARTS), .ID_W(ID_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .hartValid(hartValid), .hartWrite(hartWrite),
    .hartAddr(hartAddr), .hartWdata(hartWdata), .hartStrb(hartStrb),
    .dbgSel(dbgSel), .dbgGoReq(dbgGoReq), .dbgGoKind(dbgGoKind),
    .dbgResumeReq(dbgResumeReq), .haltedVec(haltedVec), .goVec(goVec),
    .st(st), .dbgBusy(dbgBusy));

  dmhs_data #(.NUM_HARTS(NUM_HARTS), .ID_W(ID_W), .ADDR_W(ADDR_W),
              .ABSTRACT_ADDR(ABSTRACT_ADDR), .PROGBUF_ADDR(PROGBUF_ADDR),
              .RESUME_ADDR(RESUME_ADDR)) i_data (
    .clk(clk), .rstN(rstN), .st(st), .hartValid(hartValid),
    .hartWrite(hartWrite), .hartAddr(hartAddr), .dbgSel(dbgSel),
    .hartRdata(hartRdata), .haltedVec(haltedVec), .goVec(goVec),
    .statHalted(statHalted), .statGoPending(statGoPending),
    .statResumePending(statResumePending), .statResumeAck(statResumeAck),
    .dbgException(dbgException));
endmodule

// File: tb/test_dm_hart_handshake.sv
module test_dm_hart_handshake;
  logic clk = 1'b0, rstN = 1'b0;
  logic hartValid = 1'b0, hartWrite = 1'b0;
  logic [11:0] hartAddr = '0;
  logic [31:0] hartWdata = '0;
  logic [3:0] hartStrb = '0;
  logic [31:0] hartRdata;
  logic [1:0] dbgSel = '0;
  logic dbgGoReq = 1'b0, dbgResumeReq = 1'b0;
  logic [1:0] dbgGoKind = '0;
  logic dbgBusy, statHalted, statGoPending, statResumePending, statResumeAck, dbgException;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } expItem_t;
  expItem_t sbq[$];

  always #2 clk = ~clk;

  dm_hart_handshake i_dm_hart_handshake (.*);

  function automatic logic [31:0] jal(input logic [31:0] tgt);
    logic [31:0] o;
    o = tgt - 32'h300;
    return {o[20], o[10:1], o[11], o[19:12], 5'd0, 7'h6F};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(posedge clk) begin
    if (rstN && hartValid && !hartWrite) begin
      if (sbq.size() == 0) check("scoreboard-empty", 32'd1, 32'd0);
      else begin
        expItem_t it;
        it = sbq.pop_front();
        check(it.tag, hartRdata, it.exp);
      end
    end
  end

  task automatic hartRd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    hartValid = 1'b1; hartWrite = 1'b0; hartAddr = a;
    sbq.push_back('{exp, tag});
    @(negedge clk);
    hartValid = 1'b0;
  endtask

  task automatic hartWr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    hartValid = 1'b1; hartWrite = 1'b1; hartAddr = a; hartWdata = d; hartStrb = s;
    @(negedge clk);
    hartValid = 1'b0; hartWrite = 1'b0; hartStrb = '0;
  endtask

  task automatic dbgGo(input logic [1:0] sel, input logic [1:0] kind, input logic expBusy, input string tag);
    @(negedge clk);
    dbgSel = sel; dbgGoKind = kind; dbgGoReq = 1'b1;
    #1 check(tag, 32'(dbgBusy), 32'(expBusy));
    @(negedge clk);
    dbgGoReq = 1'b0;
    @(negedge clk);
  endtask

  task automatic dbgRes(input logic [1:0] sel);
    @(negedge clk);
    dbgSel = sel; dbgResumeReq = 1'b1;
    @(negedge clk);
    dbgResumeReq = 1'b0;
  endtask

  task automatic statChk(input logic [1:0] sel, input string tag, input logic [3:0] exp);
    @(negedge clk);
    dbgSel = sel;
    #1 check(tag, 32'({statHalted, statGoPending, statResumePending, statResumeAck}), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    statChk(2'd0, "R1 hart0 status", 4'b0000);
    check("R1 exception", 32'(dbgException), 32'd0);
    hartRd(12'h400, 32'h0, "R1 flags");
    hartRd(12'h300, jal(32'h380), "R1 jump word abstract");
    // R2 halted
    hartWr(12'h100, 32'd1, 4'hF);
    hartWr(12'h100, 32'd2, 4'hF);
    statChk(2'd1, "R2 hart1 halted", 4'b1000);
    statChk(2'd0, "R2 hart0 not halted", 4'b0000);
    // R3 / R11 command to hart1, program buffer
    dbgGo(2'd1, 2'd1, 1'b0, "R3 accept busy");
    hartRd(12'h400, 32'h0000_0100, "R3 go flag lane1");
    hartRd(12'h300, jal(32'h360), "R11 jump progbuf");
    // R4 second command refused
    dbgGo(2'd2, 2'd0, 1'b1, "R4 busy raised");
    hartRd(12'h400, 32'h0000_0100, "R4 flags unchanged");
    hartRd(12'h300, jal(32'h360), "R4 jump unchanged");
    // R6 clear
    hartWr(12'h104, 32'd0, 4'hF);
    hartRd(12'h400, 32'h0, "R6 go cleared");
    // R5 not halted
    dbgGo(2'd0, 2'd0, 1'b0, "R5 no busy");
    hartRd(12'h400, 32'h0, "R5 ignored");
    // R9 exception
    hartWr(12'h10C, 32'd0, 4'hF);
    check("R9 exc set", 32'(dbgException), 32'd1);
    hartWr(12'h104, 32'd0, 4'hF);
    check("R9 exc sticky", 32'(dbgException), 32'd1);
    dbgGo(2'd2, 2'd2, 1'b0, "R9 accept");
    check("R9 exc cleared", 32'(dbgException), 32'd0);
    hartRd(12'h300, jal(32'h804), "R11 jump resume");
    hartRd(12'h400, 32'h0001_0000, "R3 go flag lane2");
    hartWr(12'h104, 32'd0, 4'hF);
    // R7 resume on two harts
    dbgRes(2'd1);
    dbgRes(2'd2);
    hartRd(12'h400, 32'h0002_0200, "R7 two resume bits");
    dbgRes(2'd3);
    hartRd(12'h400, 32'h0002_0200, "R7 non-halted ignored");
    // R8 acknowledge
    hartWr(12'h108, 32'd1, 4'hF);
    hartRd(12'h400, 32'h0002_0000, "R8 resume cleared");
    statChk(2'd1, "R8 hart1 acked", 4'b0001);
    statChk(2'd2, "R8 hart2 pending", 4'b1010);
    // R10 unmapped and strobe-less
    hartRd(12'h200, 32'h0, "R10 unmapped read");
    hartRd(12'h404, 32'h0, "R10 beyond flags");
    hartWr(12'h100, 32'd3, 4'h0);
    statChk(2'd3, "R10 zero strobe", 4'b0000);
    hartWr(12'h500, 32'hFFFF_FFFF, 4'hF);
    hartRd(12'h400, 32'h0002_0000, "R10 unmapped write");
    // R11 abstract kind
    dbgGo(2'd2, 2'd0, 1'b0, "R11 accept");
    hartRd(12'h300, jal(32'h380), "R11 jump abstract");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule